// File: doc/BRIEF.md
# Serial Frame-Delimiter Pattern Detector

This block watches a serial bit stream, one bit per clock, and reports when one of three patterns built from a run of consecutive ones has just completed. A run of five ones closed by a zero is a stuffed bit that a later stage must drop. A run of six ones closed by a zero is a frame delimiter. A seventh one in a row is a line error. Every run must begin after a zero. Each report is a single-cycle pulse on its own output.

The recognizer keeps a saturating count of the current run of ones and a two-mode controller. The zero that closes a pattern also opens the next one, so back-to-back delimiters that share a zero are both seen. After an error the controller stays quiet until a zero arrives. It does not report the error again on each further one. Removing the stuffed bit, assembling frames and checking the CRC are left to the blocks around it.

Top module: `frame_delim_detect`

## Requirements
- R1: A zero, exactly five ones, then a zero raises `stuffDrop` for one clock. The pulse appears in the cycle after the closing zero is sampled.
- R2: A zero, exactly six ones, then a zero raises `frameMark` for one clock. The pulse appears in the cycle after the closing zero is sampled.
- R3: A zero followed by seven ones raises `runError` for one clock. The pulse appears in the cycle after the seventh one is sampled.
- R4: After `runError`, further ones produce no output. The next zero produces no output either, but it counts as the leading zero of a new pattern.
- R5: After reset the detector acts as if the previous bit were zero. For example, `1111110` sent straight after reset gives one `frameMark`.
- R6: At most one of `stuffDrop`, `frameMark` and `runError` is high in any cycle.
- R7: The zero that closes a stuffed-bit or delimiter pattern serves as the leading zero of the next pattern. No idle bit is needed, so `011111101111110` gives two `frameMark` pulses.
- R8: A run of one to four ones closed by a zero produces no output. It leaves the detector as if only that zero had been received.
- R9: `rst` is synchronous and active high. All three outputs are low in every cycle after an edge at which `rst` is high. A run in progress is forgotten at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one serial bit is sampled per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| serialIn | input | 1 | Serial data bit |
| stuffDrop | output | 1 | One-cycle pulse: five ones closed by a zero |
| frameMark | output | 1 | One-cycle pulse: six ones closed by a zero |
| runError | output | 1 | One-cycle pulse: seventh consecutive one |

## Verification
On every cycle, the assertions check the following:
- The three pulses are mutually exclusive.
- Each pulse is tied to the run length and the bit sampled one edge earlier, as counted by an independent counter in the checker.
- An error pulse never repeats on the next cycle.
- The outputs stay silent after a reset edge.

The bench's scenarios are needed to show the rest, all compared bit by bit against a sliding eight-bit history model:
- A zero can be shared between back-to-back delimiters.
- The detector acts as if a zero preceded reset.
- A stuffed zero inside ordinary data is reported.
- Counting resumes after a long run of ones.
- Reset wins over a pulse that is about to appear.

// File: rtl/fdd_pkg.sv
package fdd_pkg;

  // Strobes from the controller to the run-length datapath.
  typedef struct packed {
    logic clearRun;
    logic incRun;
  } runStrobes_t;

  // Counting: runs are tracked. Overrun: waiting for a zero after an error.
  typedef enum logic [0:0] {
    MODE_COUNT   = 1'b0,
    MODE_OVERRUN = 1'b1
  } mode_e;

  typedef struct packed {
    logic drop;
    logic mark;
    logic error;
  } indications_t;

endpackage

// File: rtl/fdd_run_counter.sv
module fdd_run_counter
  import fdd_pkg::*;
#(
  parameter int unsigned STUFF_RUN = 5
) (
  input  logic        clk,
  input  logic        rst,
  input  runStrobes_t strobes,
  output logic        atStuffLen,
  output logic        atMarkLen
);

  localparam int unsigned MAX_RUN = STUFF_RUN + 2;
  localparam int unsigned CNT_W   = $clog2(MAX_RUN + 1);

  logic [CNT_W-1:0] runLen;

  // Saturating count of ones since the last zero; reset acts as a zero.
  always_ff @(posedge clk) begin
    if (rst || strobes.clearRun) begin
      runLen <= '0;
    end else if (strobes.incRun && (runLen != CNT_W'(MAX_RUN))) begin
      runLen <= runLen + 1'b1;
    end
  end

  assign atStuffLen = (runLen == CNT_W'(STUFF_RUN));
  assign atMarkLen  = (runLen == CNT_W'(STUFF_RUN + 1));

endmodule

// File: rtl/fdd_ctrl.sv
module fdd_ctrl
  import fdd_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         serialBit,
  input  logic         atStuffLen,
  input  logic         atMarkLen,
  output runStrobes_t  strobes,
  output indications_t ind
);

  mode_e        mode, modeNext;
  indications_t indNext;

  always_comb begin
    modeNext         = mode;
    strobes.clearRun = 1'b0;
    strobes.incRun   = 1'b0;
    indNext          = '0;
    unique case (mode)
      MODE_COUNT: begin
        if (serialBit) begin
          if (atMarkLen) begin
            indNext.error = 1'b1;
            modeNext      = MODE_OVERRUN;
          end else begin
            strobes.incRun = 1'b1;
          end
        end else begin
          indNext.drop     = atStuffLen;
          indNext.mark     = atMarkLen;
          strobes.clearRun = 1'b1;
        end
      end
      MODE_OVERRUN: begin
        if (!serialBit) begin
          strobes.clearRun = 1'b1;
          modeNext         = MODE_COUNT;
        end
      end
      default: modeNext = MODE_COUNT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= MODE_COUNT;
      ind  <= '0;
    end else begin
      mode <= modeNext;
      ind  <= indNext;
    end
  end

endmodule

// File: rtl/frame_delim_detect.sv
module frame_delim_detect
  import fdd_pkg::*;
#(
  parameter int unsigned STUFF_RUN = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic serialIn,
  output logic stuffDrop,
  output logic frameMark,
  output logic runError
);

  runStrobes_t  strobes;
  indications_t ind;
  logic         atStuffLen;
  logic         atMarkLen;

  fdd_run_counter #(.STUFF_RUN(STUFF_RUN)) u_runCounter (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .atStuffLen (atStuffLen),
    .atMarkLen  (atMarkLen)
  );

  fdd_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .serialBit  (serialIn),
    .atStuffLen (atStuffLen),
    .atMarkLen  (atMarkLen),
    .strobes    (strobes),
    .ind        (ind)
  );

  assign stuffDrop = ind.drop;
  assign frameMark = ind.mark;
  assign runError  = ind.error;

endmodule

// File: rtl/fdd_checker.sv
module fdd_checker #(
  parameter int unsigned STUFF_RUN = 5
) (
  input logic clk,
  input logic rst,
  input logic serialIn,
  input logic stuffDrop,
  input logic frameMark,
  input logic runError
);

  localparam int unsigned ONES_W = $clog2(STUFF_RUN + 4);
  localparam int unsigned ONES_MAX = (1 << ONES_W) - 1;

  // Independent count of consecutive ones, saturating.
  logic [ONES_W-1:0] onesSeen;
  always_ff @(posedge clk) begin
    if (rst || !serialIn) onesSeen <= '0;
    else if (onesSeen != ONES_W'(ONES_MAX)) onesSeen <= onesSeen + 1'b1;
  end

  p_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({stuffDrop, frameMark, runError}));

  p_drop_cause_r1: assert property (@(posedge clk) disable iff (rst)
    stuffDrop |-> ($past(onesSeen) == ONES_W'(STUFF_RUN) && !$past(serialIn)));

  p_drop_seen_r1: assert property (@(posedge clk) disable iff (rst)
    (onesSeen == ONES_W'(STUFF_RUN) && !serialIn) |=> stuffDrop);

  p_mark_cause_r2: assert property (@(posedge clk) disable iff (rst)
    frameMark |-> ($past(onesSeen) == ONES_W'(STUFF_RUN + 1) && !$past(serialIn)));

  p_mark_seen_r2: assert property (@(posedge clk) disable iff (rst)
    (onesSeen == ONES_W'(STUFF_RUN + 1) && !serialIn) |=> frameMark);

  p_error_cause_r3: assert property (@(posedge clk) disable iff (rst)
    runError |-> ($past(onesSeen) == ONES_W'(STUFF_RUN + 1) && $past(serialIn)));

  p_error_once_r4: assert property (@(posedge clk) disable iff (rst)
    runError |=> !runError);

  // R9: checked across reset, so no disable clause.
  p_reset_quiet_r9: assert property (@(posedge clk)
    rst |=> !(stuffDrop || frameMark || runError));

endmodule

bind frame_delim_detect fdd_checker #(.STUFF_RUN(STUFF_RUN)) u_fddChecker (
  .clk       (clk),
  .rst       (rst),
  .serialIn  (serialIn),
  .stuffDrop (stuffDrop),
  .frameMark (frameMark),
  .runError  (runError)
);

// File: tb/frame_delim_detect_test.sv
module frame_delim_detect_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic serialIn = 1'b0;
  logic stuffDrop, frameMark, runError;

  always #5 clk = ~clk;

  frame_delim_detect uut (
    .clk(clk), .rst(rst), .serialIn(serialIn),
    .stuffDrop(stuffDrop), .frameMark(frameMark), .runError(runError)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;
  logic [7:0] hist = 8'h00;
  int nDrop, nMark, nErr;

  // Vector: {length, expected drops, marks, errors, bits right-aligned, MSB sent first}
  localparam int NVEC = 9;
  localparam logic [46:0] VECS [NVEC] = '{
    {6'd7,  3'd1, 3'd0, 3'd0, 32'(7'b0111110)},                       // R1
    {6'd8,  3'd0, 3'd1, 3'd0, 32'(8'b01111110)},                      // R2
    {6'd8,  3'd0, 3'd0, 3'd1, 32'(8'b01111111)},                      // R3
    {6'd15, 3'd0, 3'd2, 3'd0, 32'(15'b011111101111110)},              // R7
    {6'd10, 3'd1, 3'd0, 3'd0, 32'(10'b1011111010)},                   // R1 stuffed zero in data
    {6'd18, 3'd1, 3'd0, 3'd1, 32'(18'b0_1111111111_0_11111_0)},       // R4
    {6'd15, 3'd0, 3'd0, 3'd0, 32'(15'b0_1_0_11_0_111_0_1111_0)},      // R8
    {6'd7,  3'd0, 3'd1, 3'd0, 32'(7'b1111110)},                       // R5
    {6'd8,  3'd0, 3'd0, 3'd1, 32'(8'b11111111)}                       // R4 eight ones
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Drive one bit, let the edge sample it, compare all outputs against the history model.
  task automatic sendBit(input logic b);
    logic eDrop, eMark, eErr;
    serialIn = b;
    @(posedge clk);
    #1;
    hist  = {hist[6:0], b};
    eDrop = (hist[6:0] == 7'b0111110);
    eMark = (hist == 8'b01111110);
    eErr  = (hist == 8'b01111111);
    check({stuffDrop, frameMark, runError} == {eDrop, eMark, eErr}, "R1 R2 R3 R6",
          "pulse vector vs model", int'({stuffDrop, frameMark, runError}),
          int'({eDrop, eMark, eErr}));
    nDrop += int'(stuffDrop);
    nMark += int'(frameMark);
    nErr  += int'(runError);
  endtask

  task automatic doReset();
    rst = 1'b1;
    serialIn = 1'b0;
    @(posedge clk);
    #1;
    check({stuffDrop, frameMark, runError} == 3'b000, "R9", "outputs in reset",
          int'({stuffDrop, frameMark, runError}), 0);
    rst  = 1'b0;
    hist = 8'h00;
  endtask

  initial begin
    repeat (2) @(posedge clk);
    #1;
    check({stuffDrop, frameMark, runError} == 3'b000, "R9", "reset state",
          int'({stuffDrop, frameMark, runError}), 0);

    for (int v = 0; v < NVEC; v++) begin
      doReset();
      nDrop = 0; nMark = 0; nErr = 0;
      for (int i = int'(VECS[v][46:41]) - 1; i >= 0; i--) sendBit(VECS[v][i]);
      serialIn = 1'b0;
      check(nDrop == int'(VECS[v][40:38]), "R1", $sformatf("drop count vec %0d", v),
            nDrop, int'(VECS[v][40:38]));
      check(nMark == int'(VECS[v][37:35]), "R2", $sformatf("mark count vec %0d", v),
            nMark, int'(VECS[v][37:35]));
      check(nErr == int'(VECS[v][34:32]), "R3", $sformatf("error count vec %0d", v),
            nErr, int'(VECS[v][34:32]));
    end

    // R9: a reset mid-run forgets the run; 0 then five ones then 0 gives a single drop.
    doReset();
    for (int i = 0; i < 5; i++) sendBit(1'b1);
    doReset();
    nDrop = 0; nMark = 0; nErr = 0;
    sendBit(1'b0);
    for (int i = 0; i < 5; i++) sendBit(1'b1);
    sendBit(1'b0);
    check(nDrop == 1 && nMark == 0, "R9", "run cleared by reset", nDrop * 10 + nMark, 10);

    // R9: reset at the edge that would produce a mark suppresses it.
    doReset();
    sendBit(1'b0);
    for (int i = 0; i < 6; i++) sendBit(1'b1);
    rst = 1'b1;
    serialIn = 1'b0;
    @(posedge clk);
    #1;
    check(frameMark == 1'b0, "R9", "mark suppressed by reset", int'(frameMark), 0);
    rst = 1'b0;
    hist = 8'h00;

    // R4: long overrun, then a closing zero and a clean delimiter.
    nDrop = 0; nMark = 0; nErr = 0;
    for (int i = 0; i < 20; i++) sendBit(1'b1);
    sendBit(1'b0);
    check(nErr == 1, "R4", "single error over long run", nErr, 1);
    for (int i = 0; i < 6; i++) sendBit(1'b1);
    sendBit(1'b0);
    check(nMark == 1 && nDrop == 0, "R4", "mark after overrun", nMark, 1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule